// File: doc/BRIEF.md
# Command-Response Packet Byte Parser

This block sits behind the receive path of a master-slave command-response bus. It takes one protocol packet as a stream of bytes and splits it into its fields. A strobe marks each valid byte, and a start flag on the first byte opens a new packet. The fixed 16-byte header carries the following fields:

- the destination and source node numbers
- a command code
- a six-byte address offset
- four bytes of inline data
- an acknowledge command byte and an acknowledge status byte
- a header check byte

The command code names one of eight packet kinds. Four of those kinds carry a data payload. For them the parser passes the payload bytes on as a stream with a last-byte marker, and then latches the trailing data check byte.

The parser does not compute check bytes. It only presents the received check bytes, so that an external comparator can verify them. It reports the end of each good packet with a one-cycle done pulse. Every captured field then holds its value until the bytes of the next packet overwrite it. An unknown command code, or a start flag that arrives in the middle of a packet, produces a one-cycle error pulse. In the first case the parser drops the rest of the packet. In the second case it begins parsing a new packet at the byte that carried the start flag.

Top module: `cmdrsp_pkt_parser`

## Requirements
- R1: After reset every captured field is zero, `kind_valid`, `is_long`, `pay_len`, `done`, `err`, `pay_valid` and `pay_last` are low, and bytes without a start flag leave all of them unchanged.
- R2: Header bytes map by their position within the packet:
  - byte 0 to `dst_node`
  - byte 1 to `src_node`
  - byte 2 to `cmd_code`
  - bytes 3 to 8 to `addr_offset`, with byte 3 as bits 47:40
  - bytes 9 to 12 to `short_data`, with byte 9 as bits 31:24
  - byte 13 to `ack_cmd`
  - byte 14 to `ack_status`
  - byte 15 to `hdr_check`
- R3: Command codes 0x01 to 0x08 are known, and `pkt_kind` equals the code minus one. The codes stand for I/O read, I/O write, memory read, memory write, configuration read, configuration write, response with data and response without data, in that order. Codes 0x02, 0x04, 0x06 and 0x07 set `is_long`, and `pay_len` then reads PAYLOAD_BYTES. For every other known code both read zero.
- R4: For a short packet, `done` is high for exactly the one cycle after header byte 15 is accepted, and no payload is emitted.
- R5: For a long packet, the PAYLOAD_BYTES bytes after the header appear on `pay_byte` with `pay_valid`, each one cycle after it is accepted. `pay_last` marks the final payload byte. The next byte is latched in `data_check`, and `done` pulses one cycle after that byte.
- R6: `resp_active` follows bit 7 of the captured acknowledge status byte.
- R7: A code outside 0x01 to 0x08 in byte 2 raises `err` for the one cycle after that byte. The parser then ignores bytes until the next start flag, with no `done` and no field change.
- R8: A start flag inside a packet (in header, payload or data check) raises `err` for one cycle after it. That byte becomes byte 0 of a new packet, and this new packet is parsed normally.
- R9: Cycles with `in_valid` low leave all state and outputs unchanged, so gaps between bytes do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | First byte of a packet (with in_valid) |
| in_byte | input | 8 | Received byte |
| dst_node | output | 8 | Destination node |
| src_node | output | 8 | Source node |
| cmd_code | output | 8 | Raw command code |
| addr_offset | output | 48 | Address offset, first byte most significant |
| short_data | output | 32 | Inline header data, first byte most significant |
| ack_cmd | output | 8 | Acknowledge command |
| ack_status | output | 8 | Acknowledge status |
| hdr_check | output | 8 | Received header check byte |
| data_check | output | 8 | Received payload check byte |
| kind_valid | output | 1 | Captured command code is known |
| pkt_kind | output | 3 | Packet kind index |
| is_long | output | 1 | Packet kind carries a payload |
| pay_len | output | clog2(PAYLOAD_BYTES+1) | Expected payload length |
| resp_active | output | 1 | Response carries useful content |
| pay_valid | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte |
| done | output | 1 | One-cycle pulse at the end of a good packet |
| err | output | 1 | One-cycle pulse on an unknown code or an aborted packet |

## Verification
The properties assume that `in_sop` has meaning only together with `in_valid`. They also assume that the byte following a payload's last byte is either its check byte or a fresh start. The bench never raises the start flag without the strobe. It sends every header and payload in full unless it is deliberately aborting a packet, and every abort is a start-flagged byte. Idle gaps are placed only where `in_valid` is low, so the stimulus never presents a partial or overlapping byte.

// File: rtl/pktp_pkg.sv
package pktp_pkg;
  localparam int HDR_BYTES   = 16;
  localparam int HDR_IDX_W   = $clog2(HDR_BYTES);
  localparam int POS_DST     = 0;
  localparam int POS_SRC     = 1;
  localparam int POS_CMD     = 2;
  localparam int POS_ADDR    = 3;
  localparam int ADDR_BYTES  = 6;
  localparam int POS_SDATA   = POS_ADDR + ADDR_BYTES;
  localparam int SDATA_BYTES = 4;
  localparam int POS_ACKC    = POS_SDATA + SDATA_BYTES;
  localparam int POS_ACKS    = POS_ACKC + 1;
  localparam int POS_HCHK    = POS_ACKS + 1;

  typedef enum logic [2:0] {
    K_IO_RD, K_IO_WR, K_MEM_RD, K_MEM_WR,
    K_CFG_RD, K_CFG_WR, K_RSP_DATA, K_RSP_NODATA
  } pkt_kind_e;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_DCHK, S_DROP} seq_st_e;

  function automatic logic code_known(input logic [7:0] c);
    return (c >= 8'd1) && (c <= 8'd8);
  endfunction

  function automatic pkt_kind_e code_kind(input logic [7:0] c);
    logic [7:0] t;
    t = c - 8'd1;
    return pkt_kind_e'(t[2:0]);
  endfunction

  function automatic logic kind_long(input pkt_kind_e k);
    return (k == K_IO_WR) || (k == K_MEM_WR) || (k == K_CFG_WR) || (k == K_RSP_DATA);
  endfunction
endpackage

// File: rtl/pktp_type_decode.sv
module pktp_type_decode
  import pktp_pkg::*;
(
  input  logic [7:0] code,
  output logic       known,
  output logic [2:0] kind,
  output logic       long_pkt
);
  pkt_kind_e k;
  always_comb begin
    k        = code_kind(code);
    known    = code_known(code);
    kind     = known ? k : 3'd0;
    long_pkt = known && kind_long(k);
  end
endmodule

// File: rtl/pktp_hdr_fields.sv
module pktp_hdr_fields
  import pktp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [HDR_IDX_W-1:0] wr_idx,
  input  logic [7:0]           wr_byte,
  input  logic                 dchk_en,
  output logic [7:0]           dst_q,
  output logic [7:0]           src_q,
  output logic [7:0]           cmd_q,
  output logic [8*ADDR_BYTES-1:0]  addr_q,
  output logic [8*SDATA_BYTES-1:0] sdata_q,
  output logic [7:0]           ackc_q,
  output logic [7:0]           acks_q,
  output logic [7:0]           hchk_q,
  output logic [7:0]           dchk_q
);
  logic [ADDR_BYTES-1:0]  addr_we;
  logic [SDATA_BYTES-1:0] sdata_we;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_we
    assign addr_we[g] = wr_en && (wr_idx == HDR_IDX_W'(POS_ADDR + g));
  end
  for (genvar g = 0; g < SDATA_BYTES; g++) begin : g_sdata_we
    assign sdata_we[g] = wr_en && (wr_idx == HDR_IDX_W'(POS_SDATA + g));
  end

  function automatic logic hit(input logic en, input logic [HDR_IDX_W-1:0] idx, input int pos);
    return en && (idx == HDR_IDX_W'(pos));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      src_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      sdata_q <= '0;
      ackc_q  <= '0;
      acks_q  <= '0;
      hchk_q  <= '0;
      dchk_q  <= '0;
    end else begin
      if (hit(wr_en, wr_idx, POS_DST))  dst_q  <= wr_byte;
      if (hit(wr_en, wr_idx, POS_SRC))  src_q  <= wr_byte;
      if (hit(wr_en, wr_idx, POS_CMD))  cmd_q  <= wr_byte;
      if (hit(wr_en, wr_idx, POS_ACKC)) ackc_q <= wr_byte;
      if (hit(wr_en, wr_idx, POS_ACKS)) acks_q <= wr_byte;
      if (hit(wr_en, wr_idx, POS_HCHK)) hchk_q <= wr_byte;
      for (int j = 0; j < ADDR_BYTES; j++)
        if (addr_we[j]) addr_q[(ADDR_BYTES-1-j)*8 +: 8] <= wr_byte;
      for (int j = 0; j < SDATA_BYTES; j++)
        if (sdata_we[j]) sdata_q[(SDATA_BYTES-1-j)*8 +: 8] <= wr_byte;
      if (dchk_en) dchk_q <= wr_byte;
    end
  end
endmodule

// File: rtl/pktp_seq.sv
module pktp_seq
  import pktp_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 1024,
  localparam int PAY_CW = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic [7:0]           in_byte,
  input  logic                 cmd_known_in,
  input  logic                 hdr_long,
  output logic                 hdr_wr,
  output logic [HDR_IDX_W-1:0] hdr_idx_w,
  output logic                 dchk_wr,
  output logic                 pay_valid_q,
  output logic [7:0]           pay_byte_q,
  output logic                 pay_last_q,
  output logic                 done_q,
  output logic                 err_q,
  output logic                 ev_abort,
  output logic                 ev_badcmd,
  output logic                 ev_hdr_end,
  output logic                 ev_pay_end
);
  localparam logic [PAY_CW-1:0] PAY_LAST = PAY_CW'(PAYLOAD_BYTES - 1);
  localparam logic [HDR_IDX_W-1:0] IDX_END = HDR_IDX_W'(HDR_BYTES - 1);

  seq_st_e               st, st_n;
  logic [HDR_IDX_W-1:0]  hdr_idx;
  logic [PAY_CW-1:0]     pay_cnt;
  logic                  start, cont, in_hdr, pay_beat;

  always_comb begin
    start      = in_valid && in_sop;
    cont       = in_valid && !in_sop;
    in_hdr     = cont && (st == S_HDR);
    ev_abort   = start && ((st == S_HDR) || (st == S_PAY) || (st == S_DCHK));
    hdr_wr     = start || in_hdr;
    hdr_idx_w  = start ? '0 : hdr_idx;
    ev_badcmd  = in_hdr && (hdr_idx == HDR_IDX_W'(POS_CMD)) && !cmd_known_in;
    ev_hdr_end = in_hdr && (hdr_idx == IDX_END);
    pay_beat   = cont && (st == S_PAY);
    ev_pay_end = pay_beat && (pay_cnt == PAY_LAST);
    dchk_wr    = cont && (st == S_DCHK);

    st_n = st;
    if (start)           st_n = S_HDR;
    else if (ev_badcmd)  st_n = S_DROP;
    else if (ev_hdr_end) st_n = hdr_long ? S_PAY : S_IDLE;
    else if (ev_pay_end) st_n = S_DCHK;
    else if (dchk_wr)    st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      hdr_idx     <= '0;
      pay_cnt     <= '0;
      pay_valid_q <= 1'b0;
      pay_byte_q  <= '0;
      pay_last_q  <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st <= st_n;
      if (start)       hdr_idx <= HDR_IDX_W'(1);
      else if (in_hdr) hdr_idx <= hdr_idx + 1'b1;
      if (ev_hdr_end)    pay_cnt <= '0;
      else if (pay_beat) pay_cnt <= pay_cnt + 1'b1;
      pay_valid_q <= pay_beat;
      if (pay_beat) pay_byte_q <= in_byte;
      pay_last_q  <= ev_pay_end;
      done_q      <= (ev_hdr_end && !hdr_long) || dchk_wr;
      err_q       <= ev_abort || ev_badcmd;
    end
  end
endmodule

// File: rtl/cmdrsp_pkt_parser.sv
module cmdrsp_pkt_parser
  import pktp_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 1024,
  localparam int LEN_W = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_byte,
  output logic [7:0]        dst_node,
  output logic [7:0]        src_node,
  output logic [7:0]        cmd_code,
  output logic [47:0]       addr_offset,
  output logic [31:0]       short_data,
  output logic [7:0]        ack_cmd,
  output logic [7:0]        ack_status,
  output logic [7:0]        hdr_check,
  output logic [7:0]        data_check,
  output logic              kind_valid,
  output logic [2:0]        pkt_kind,
  output logic              is_long,
  output logic [LEN_W-1:0]  pay_len,
  output logic              resp_active,
  output logic              pay_valid,
  output logic [7:0]        pay_byte,
  output logic              pay_last,
  output logic              done,
  output logic              err
);
  logic                 hdr_wr, dchk_wr;
  logic [HDR_IDX_W-1:0] hdr_idx_w;
  logic                 in_known;
  logic [2:0]           in_kind_unused;
  logic                 in_long_unused;
  logic                 ev_abort, ev_badcmd, ev_hdr_end, ev_pay_end;

  pktp_type_decode u_in_dec (
    .code(in_byte), .known(in_known), .kind(in_kind_unused), .long_pkt(in_long_unused)
  );

  pktp_type_decode u_hdr_dec (
    .code(cmd_code), .known(kind_valid), .kind(pkt_kind), .long_pkt(is_long)
  );

  pktp_hdr_fields u_fields (
    .clk(clk), .rst_n(rst_n), .wr_en(hdr_wr), .wr_idx(hdr_idx_w), .wr_byte(in_byte),
    .dchk_en(dchk_wr), .dst_q(dst_node), .src_q(src_node), .cmd_q(cmd_code),
    .addr_q(addr_offset), .sdata_q(short_data), .ackc_q(ack_cmd), .acks_q(ack_status),
    .hchk_q(hdr_check), .dchk_q(data_check)
  );

  pktp_seq #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
    .cmd_known_in(in_known), .hdr_long(is_long), .hdr_wr(hdr_wr), .hdr_idx_w(hdr_idx_w),
    .dchk_wr(dchk_wr), .pay_valid_q(pay_valid), .pay_byte_q(pay_byte),
    .pay_last_q(pay_last), .done_q(done), .err_q(err), .ev_abort(ev_abort),
    .ev_badcmd(ev_badcmd), .ev_hdr_end(ev_hdr_end), .ev_pay_end(ev_pay_end)
  );

  assign pay_len     = is_long ? LEN_W'(PAYLOAD_BYTES) : '0;
  assign resp_active = ack_status[7];
endmodule

// File: rtl/pktp_chk.sv
module pktp_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         ev_abort,
  input logic         ev_badcmd,
  input logic         ev_hdr_end,
  input logic         is_long,
  input logic         done,
  input logic         err,
  input logic         pay_valid,
  input logic         pay_last,
  input logic [135:0] fields
);
  // R8
  abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_abort |=> err);
  // R7
  badcmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_badcmd |=> (err && !done));
  // R4
  short_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hdr_end && !is_long) |=> (done && !pay_valid));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) pay_last |-> pay_valid);
  // R5
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n) pay_last |=> !pay_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(fields));
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
endmodule

bind cmdrsp_pkt_parser pktp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ev_abort(ev_abort),
  .ev_badcmd(ev_badcmd), .ev_hdr_end(ev_hdr_end), .is_long(is_long), .done(done),
  .err(err), .pay_valid(pay_valid), .pay_last(pay_last),
  .fields({dst_node, src_node, cmd_code, addr_offset, short_data, ack_cmd,
           ack_status, hdr_check, data_check})
);

// File: tb/sim_cmdrsp_pkt_parser.sv
module sim_cmdrsp_pkt_parser;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 8;
  localparam int LW = $clog2(PB + 1);

  logic clk = 0, rst_n = 0, in_valid = 0, in_sop = 0;
  logic [7:0] in_byte = 0;
  logic [7:0] dst_node, src_node, cmd_code, ack_cmd, ack_status, hdr_check, data_check, pay_byte;
  logic [47:0] addr_offset;
  logic [31:0] short_data;
  logic kind_valid, is_long, resp_active, pay_valid, pay_last, done, err;
  logic [2:0] pkt_kind;
  logic [LW-1:0] pay_len;

  cmdrsp_pkt_parser #(.PAYLOAD_BYTES(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
    .dst_node(dst_node), .src_node(src_node), .cmd_code(cmd_code), .addr_offset(addr_offset),
    .short_data(short_data), .ack_cmd(ack_cmd), .ack_status(ack_status), .hdr_check(hdr_check),
    .data_check(data_check), .kind_valid(kind_valid), .pkt_kind(pkt_kind), .is_long(is_long),
    .pay_len(pay_len), .resp_active(resp_active), .pay_valid(pay_valid), .pay_byte(pay_byte),
    .pay_last(pay_last), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int pay_seen = 0, pay_bad = 0, pkt_base = 0, cur_seed = 0, done_seen = 0, err_seen = 0;

  function automatic logic [7:0] hb(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + 3);
  endfunction
  function automatic logic [7:0] pb(input int seed, input int k);
    return 8'(seed * 5 + k * 29 + 1);
  endfunction
  function automatic logic [7:0] dc(input int seed);
    return 8'(seed) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pay_valid) begin
        if (pay_byte !== pb(cur_seed, pay_seen - pkt_base)) pay_bad++;
        pay_seen++;
      end
      if (done) done_seen++;
      if (err)  err_seen++;
    end
  end

  task automatic put(input logic [7:0] b, input bit sop);
    @(negedge clk); in_valid = 1; in_byte = b; in_sop = sop;
  endtask
  task automatic gap();
    @(negedge clk); in_valid = 0; in_sop = 0; in_byte = 8'h5A;
  endtask

  task automatic send_pkt(input int seed, input logic [7:0] code, input bit gaps, input bit abort);
    bit known, lng;
    logic [47:0] prev_addr, ea;
    logic [31:0] es;
    int d0, e0, pb0, bad0;
    known = (code >= 1) && (code <= 8);
    lng = known && (code == 2 || code == 4 || code == 6 || code == 7);
    prev_addr = addr_offset;
    d0 = done_seen; e0 = err_seen; bad0 = pay_bad;
    cur_seed = seed; pkt_base = pay_seen; pb0 = pay_seen;
    for (int i = 0; i < 16; i++) begin
      put((i == 2) ? code : hb(seed, i), i == 0);
      if (abort && i == 0) begin
        gap(); chk(err === 1'b1, "R8", "err after mid-packet start", err, 1);
      end
      if (i == 2 && !known) begin
        gap(); chk(err === 1'b1, "R7", "err after unknown code", err, 1);
      end
      if (gaps && (i % 3 == 1)) gap();
    end
    if (lng) begin
      for (int k = 0; k < PB; k++) begin
        put(pb(seed, k), 0);
        if (gaps && k == 3) gap();
      end
      put(dc(seed), 0);
      chk(pay_valid === 1'b1 && pay_last === 1'b1, "R5", "last payload marker", {pay_valid, pay_last}, 3);
    end
    gap();
    chk(done === known, known ? (lng ? "R5" : "R4") : "R7", "done one cycle after end", done, known);
    gap();
    chk(done === 1'b0, "R4", "done is a single pulse", done, 0);
    chk(err_seen - e0 == (abort ? 1 : 0) + (known ? 0 : 1), "R8", "err pulse count", err_seen - e0, (abort ? 1 : 0) + (known ? 0 : 1));
    chk(kind_valid === known, "R3", "kind_valid", kind_valid, known);
    chk(pay_seen - pb0 == (lng ? PB : 0), "R5", "payload byte count", pay_seen - pb0, lng ? PB : 0);
    if (known) begin
      ea = '0; es = '0;
      for (int j = 0; j < 6; j++) ea = {ea[39:0], hb(seed, 3 + j)};
      for (int j = 0; j < 4; j++) es = {es[23:0], hb(seed, 9 + j)};
      chk(dst_node === hb(seed, 0) && src_node === hb(seed, 1), "R2", "node bytes",
          {dst_node, src_node}, {hb(seed, 0), hb(seed, 1)});
      chk(cmd_code === code, "R2", "command byte", cmd_code, code);
      chk(addr_offset === ea, "R2", "address offset", addr_offset, ea);
      chk(short_data === es, "R2", "inline data", short_data, es);
      chk(ack_cmd === hb(seed, 13) && ack_status === hb(seed, 14) && hdr_check === hb(seed, 15),
          "R2", "ack and check bytes", {ack_cmd, ack_status, hdr_check},
          {hb(seed, 13), hb(seed, 14), hb(seed, 15)});
      chk(pkt_kind === 3'(code - 1), "R3", "kind index", pkt_kind, code - 1);
      chk(is_long === lng && pay_len === (lng ? LW'(PB) : LW'(0)), "R3", "long and length",
          {is_long, pay_len}, {lng, (lng ? LW'(PB) : LW'(0))});
      chk(resp_active === hb(seed, 14)[7], "R6", "active flag", resp_active, hb(seed, 14)[7]);
      chk(done_seen - d0 == 1, "R4", "one done per packet", done_seen - d0, 1);
      if (lng) begin
        chk(data_check === dc(seed), "R5", "data check byte", data_check, dc(seed));
        chk(pay_bad == bad0, "R5", "payload byte values", pay_bad - bad0, 0);
      end
    end else begin
      chk(addr_offset === prev_addr, "R7", "dropped bytes leave address", addr_offset, prev_addr);
      chk(done_seen == d0, "R7", "no done after unknown code", done_seen - d0, 0);
    end
  endtask

  task automatic partial(input int seed, input logic [7:0] code, input int n);
    cur_seed = seed; pkt_base = pay_seen;
    for (int i = 0; i < n; i++)
      put((i == 0 || i > 15) ? ((i == 0) ? hb(seed, 0) : pb(seed, i - 16))
                             : ((i == 2) ? code : hb(seed, i)), i == 0);
    gap(); gap();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d_keep;
    int d0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done === 0 && err === 0 && pay_valid === 0 && pay_last === 0, "R1", "reset flags",
        {done, err, pay_valid, pay_last}, 0);
    chk(addr_offset === 0 && dst_node === 0 && kind_valid === 0 && is_long === 0 && pay_len === 0,
        "R1", "reset fields", addr_offset, 0);
    rst_n = 1;
    gap();
    // R1 stray bytes before any start are ignored
    for (int i = 0; i < 4; i++) put(8'hC3, 0);
    gap(); gap();
    chk(dst_node === 0 && cmd_code === 0 && done_seen == 0 && pay_seen == 0, "R1",
        "stray bytes ignored", dst_node, 0);
    // R2 R3 R4 R5 R7 R9: every command code, gaps on odd codes
    for (int c = 0; c < 256; c++) send_pkt(c + 40, 8'(c), c[0], 0);
    // R9 idle bytes after done leave fields alone
    d_keep = dst_node; d0 = done_seen; p0 = pay_seen;
    for (int i = 0; i < 5; i++) put(8'hFF, 0);
    gap(); gap();
    chk(dst_node === d_keep && done_seen == d0 && pay_seen == p0, "R9", "idle bytes ignored",
        dst_node, d_keep);
    // R8 aborts in header, payload and data check phases
    partial(500, 8'h04, 7);
    send_pkt(501, 8'h07, 0, 1);
    partial(502, 8'h02, 19);
    send_pkt(503, 8'h01, 1, 1);
    partial(504, 8'h06, 16 + PB);
    send_pkt(505, 8'h08, 0, 1);
    // R8 start during drop is a clean start
    send_pkt(506, 8'h55, 0, 0);
    send_pkt(507, 8'h03, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule